// File: doc/BRIEF.md
# Mode-Switchable Instruction Cache

A read-only instruction cache placed between a fetch port and a line-fill memory. The same storage runs in one of two organisations, and a single control bit picks between them. With the bit clear, the cache is direct-mapped: only way 0 is looked up and filled, giving 256 lines of 32 bytes (8 KB). With the bit set, both ways are in use as a 2-way set-associative cache with 256 sets (16 KB). On a miss the victim way is chosen by least-recently-used replacement. Every reset clears the bit, so the cache always starts in the direct-mapped organisation.

The fetch side presents a word address with `fetch_valid` and holds it. `fetch_ready` rises in the cycle the instruction word on `fetch_data` is delivered. On a miss the block asks the memory for one aligned 32-byte line and waits for the request to be accepted. It then takes eight 32-bit beats, marks the line valid, and only after that answers the fetch from the array. A pulse on `inv_all` drops every line over a bounded sweep. The fetch port is held off while the sweep runs.

Top module: `icache_modal`

## Requirements
- R1: After reset the cache is in direct-mapped mode, holds no valid line, and drives `fetch_ready` and `mem_req_valid` low. The first fetch after reset misses.
- R2: A byte address splits into word-in-line bits [4:2], set index bits [12:5] and tag bits [31:13]. A refill request carries the 32-byte-aligned byte address of the missing line. Words of the same line hit once that line is filled.
- R3: With the mode bit clear, lookups and refills use way 0 only. Two addresses with the same index and different tags evict each other.
- R4: With the mode bit set, two lines with the same index and different tags can be resident at once, one in each way.
- R5: With the mode bit set, a refill goes to an invalid way (way 0 first) when one exists, and otherwise to the least-recently-used way. A hit or a refill makes its way the most recently used.
- R6: A write of the mode bit that changes its value invalidates every way-1 line and leaves way-0 lines valid.
- R7: A miss stalls the fetch. `fetch_ready` stays low until all eight beats are taken, then rises in the following cycle with the word just written. A miss takes at least 11 cycles from presentation to delivery.
- R8: A pulse on `inv_all` invalidates all lines in both ways. The sweep lasts 256 cycles and starts once any refill in progress has completed. `fetch_ready` is low throughout, and fetches afterwards return the memory's current contents.
- R9: A fetch that hits is answered in the cycle it is first presented (combinational `fetch_ready`), with no refill request.
- R10: Once raised, `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also clears the mode bit |
| cfg_we | input | 1 | Write strobe for the mode bit |
| cfg_ext | input | 1 | Mode bit value: 1 = 2-way LRU, 0 = direct-mapped |
| inv_all | input | 1 | Pulse: invalidate every line |
| fetch_valid | input | 1 | Fetch request present, held until `fetch_ready` |
| fetch_waddr | input | 30 | Fetch word address (byte address bits [31:2]) |
| fetch_ready | output | 1 | Fetch answered this cycle |
| fetch_data | output | 32 | Instruction word, valid with `fetch_ready` |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_addr | output | 32 | Byte address of the line, 32-byte aligned |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_beat_valid | input | 1 | Refill beat present |
| mem_beat_data | input | 32 | Refill beat word, in ascending word order |

## Verification
Directed runs first fetch words inside one line and then across lines, which separates the line granularity from the index split. Three to four tags sharing one index are then cycled in both modes. That separates direct-mapped eviction from two-way residency, and true LRU from FIFO order: after a hit on the older line, a FIFO policy would evict the wrong way. Mode flips with lines resident show that only way 1 is lost. An invalidate followed by a change of memory contents exposes any stale line that survives the sweep. A long random mix of fetches from a small conflicting pool is then run with random mode writes, invalidates arriving during refills, and irregular request-accept and beat gaps. Every cycle of this mix is compared against a behavioural model for the handshake timing, the request address and the returned word.

// File: rtl/icache_modal_pkg.sv
package icache_modal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_SWEEP
  } ic_state_e;

  // Way chosen for a refill: first invalid way, else the LRU way.
  // The direct-mapped organisation always refills way 0.
  function automatic logic pick_victim(input logic v0, input logic v1,
                                       input logic lru, input logic ext);
    if (!ext) return 1'b0;
    if (!v0)  return 1'b0;
    if (!v1)  return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic             wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             lru_we,
  input  logic [IDX_W-1:0] lru_idx,
  input  logic             lru_val,
  input  logic             sweep_en,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic             drop_way1,
  output logic             hit,
  output logic             hit_way,
  output logic             victim
);
  import icache_modal_pkg::*;

  logic [1:0]      match;
  logic [1:0]      vld_at;
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld;
    logic [TAG_W-1:0] tagm [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
      end else begin
        if (wr_en && wr_way == 1'(w)) vld[wr_idx] <= 1'b1;
        if (sweep_en)                 vld[sweep_idx] <= 1'b0;
        if (drop_way1 && w == 1)      vld <= '0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) tagm[wr_idx] <= wr_tag;
    end

    assign vld_at[w] = vld[lk_idx];
    assign match[w]  = vld[lk_idx] && (tagm[lk_idx] == lk_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_we) lru_q[lru_idx] <= lru_val;
  end

  assign hit     = match[0] || (ext_mode && match[1]);
  assign hit_way = !match[0];
  assign victim  = pick_victim(vld_at[0], vld_at[1], lru_q[lk_idx], ext_mode);

endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int SETS       = 256,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32,
  localparam int DEPTH     = 2 * SETS * LINE_WORDS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
  parameter int SETS       = 256,
  parameter int LINE_WORDS = 8,
  parameter int LINE_W     = 27,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ext,
  input  logic              inv_all,
  input  logic              fetch_valid,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              hit,
  input  logic              victim,
  input  logic              mem_req_ready,
  input  logic              mem_beat_valid,
  output logic              ext_mode,
  output logic              fetch_ready,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_way,
  output logic [WSEL_W-1:0] fill_beat,
  output logic              data_we,
  output logic              fill_done,
  output logic              fill_busy,
  output logic              sweep_busy,
  output logic [IDX_W-1:0]  sweep_idx,
  output logic              drop_way1
);
  import icache_modal_pkg::*;

  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SET  = IDX_W'(SETS - 1);

  ic_state_e st_q;
  logic      inv_pend_q;
  logic      lookup_ok;
  logic      miss_take;

  always_comb begin
    lookup_ok     = (st_q == ST_IDLE) && !inv_pend_q && fetch_valid;
    fetch_ready   = lookup_ok && hit;
    miss_take     = lookup_ok && !hit;
    mem_req_valid = (st_q == ST_REQ);
    data_we       = (st_q == ST_FILL) && mem_beat_valid;
    fill_done     = data_we && (fill_beat == LAST_BEAT);
    fill_busy     = (st_q == ST_REQ) || (st_q == ST_FILL);
    sweep_busy    = (st_q == ST_SWEEP);
    drop_way1     = cfg_we && (cfg_ext != ext_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      inv_pend_q <= 1'b0;
      ext_mode   <= 1'b0;
      fill_line  <= '0;
      fill_way   <= 1'b0;
      fill_beat  <= '0;
      sweep_idx  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (inv_pend_q) begin
            st_q      <= ST_SWEEP;
            sweep_idx <= '0;
          end else if (miss_take) begin
            st_q      <= ST_REQ;
            fill_line <= lk_line;
            fill_way  <= victim;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            st_q      <= ST_FILL;
            fill_beat <= '0;
          end
        end
        ST_FILL: begin
          if (mem_beat_valid) begin
            fill_beat <= fill_beat + 1'b1;
            if (fill_beat == LAST_BEAT) st_q <= ST_IDLE;
          end
        end
        ST_SWEEP: begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == LAST_SET) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (inv_all)              inv_pend_q <= 1'b1;
      else if (st_q == ST_IDLE) inv_pend_q <= 1'b0;

      if (cfg_we) ext_mode <= cfg_ext;
    end
  end

endmodule

// File: rtl/icache_modal.sv
module icache_modal #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 256,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32,
  localparam int BYTE_W    = $clog2(DATA_W / 8),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = BYTE_W + WSEL_W,
  localparam int WA_W      = ADDR_W - BYTE_W,
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int TAG_W     = LINE_W - IDX_W,
  localparam int DAW       = 1 + IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ext,
  input  logic              inv_all,
  input  logic              fetch_valid,
  input  logic [WA_W-1:0]   fetch_waddr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data
);

  function automatic logic [LINE_W-1:0] line_of(input logic [WA_W-1:0] wa);
    return wa[WA_W-1:WSEL_W];
  endfunction
  function automatic logic [WSEL_W-1:0] word_of(input logic [WA_W-1:0] wa);
    return wa[WSEL_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] ln);
    return ln[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] ln);
    return ln[LINE_W-1:IDX_W];
  endfunction

  // Named internal events
  logic              ext_mode, hit, hit_way, victim;
  logic              fill_way, data_we, fill_done, fill_busy;
  logic              sweep_busy, drop_way1, tag_we, lru_we, lru_val;
  logic [LINE_W-1:0] lk_line, fill_line;
  logic [WSEL_W-1:0] fill_beat;
  logic [IDX_W-1:0]  sweep_idx, lru_idx;

  assign lk_line      = line_of(fetch_waddr);
  assign mem_req_addr = {fill_line, {OFF_W{1'b0}}};
  assign tag_we       = fill_done && (!fill_way || ext_mode);
  assign lru_we       = ext_mode && (fetch_ready || fill_done);
  assign lru_idx      = fetch_ready ? idx_of(lk_line) : idx_of(fill_line);
  assign lru_val      = fetch_ready ? !hit_way : !fill_way;

  icache_ctrl #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext),
    .inv_all(inv_all), .fetch_valid(fetch_valid), .lk_line(lk_line),
    .hit(hit), .victim(victim), .mem_req_ready(mem_req_ready),
    .mem_beat_valid(mem_beat_valid), .ext_mode(ext_mode),
    .fetch_ready(fetch_ready), .mem_req_valid(mem_req_valid),
    .fill_line(fill_line), .fill_way(fill_way), .fill_beat(fill_beat),
    .data_we(data_we), .fill_done(fill_done), .fill_busy(fill_busy),
    .sweep_busy(sweep_busy), .sweep_idx(sweep_idx), .drop_way1(drop_way1)
  );

  icache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .lk_idx(idx_of(lk_line)), .lk_tag(tag_of(lk_line)),
    .wr_en(tag_we), .wr_way(fill_way), .wr_idx(idx_of(fill_line)),
    .wr_tag(tag_of(fill_line)), .lru_we(lru_we), .lru_idx(lru_idx),
    .lru_val(lru_val), .sweep_en(sweep_busy), .sweep_idx(sweep_idx),
    .drop_way1(drop_way1), .hit(hit), .hit_way(hit_way), .victim(victim)
  );

  icache_data #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(data_we),
    .wr_addr(DAW'({fill_way, idx_of(fill_line), fill_beat})),
    .wr_data(mem_beat_data),
    .rd_addr(DAW'({hit_way, idx_of(lk_line), word_of(fetch_waddr)})),
    .rd_data(fetch_data)
  );

endmodule

// File: rtl/icache_modal_chk.sv
module icache_modal_chk #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              sweep_busy,
  input logic              fill_busy,
  input logic              fill_done,
  input logic              ext_mode,
  input logic              hit_way
);
  int unsigned sweep_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sweep_len <= 0;
    else if (sweep_busy) sweep_len <= sweep_len + 1;
    else                 sweep_len <= 0;
  end

  AST_NO_READY_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !fetch_ready); // R8
  AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> sweep_len < SETS); // R8
  AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !fetch_ready); // R7
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_busy); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_COMPAT_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready && !ext_mode |-> !hit_way); // R3

endmodule

bind icache_modal icache_modal_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .sweep_busy(sweep_busy),
  .fill_busy(fill_busy), .fill_done(fill_done), .ext_mode(ext_mode),
  .hit_way(hit_way)
);

// File: tb/icache_modal_tb.sv
module icache_modal_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_ext = 1'b0, inv_all = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fa = '0;
  logic        fetch_ready, mem_req_valid;
  logic [31:0] fetch_data, mem_req_addr;
  logic        mem_req_ready = 1'b0, mem_beat_valid = 1'b0;
  logic [31:0] mem_beat_data = '0;

  always #5 clk = ~clk;

  icache_modal u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext),
    .inv_all(inv_all), .fetch_valid(fetch_valid), .fetch_waddr(fa[31:2]),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_beat_valid(mem_beat_valid),
    .mem_beat_data(mem_beat_data)
  );

  int total = 0, bad = 0, ncyc = 0;
  string cur_req = "R1";
  logic [31:0] epoch = 32'h0;
  logic [31:0] rnd = 32'h1234_5678;
  logic        last_ready;

  // Behavioural model: 0 idle, 1 request, 2 refill, 3 sweep
  int          mph = 0, mbeat = 0, msw = 0, mway = 0;
  bit          mext = 0, mpend = 0;
  logic [31:0] mline = '0;
  bit          mv [2][256];
  int          mt [2][256];
  bit          ml [256];
  logic [31:0] md [2][256][8];

  function automatic logic [31:0] memfun(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ epoch;
  endfunction
  function automatic int set_of(input logic [31:0] a);
    return int'((a >> 5) & 32'hFF);
  endfunction
  function automatic int tag_of(input logic [31:0] a);
    return int'(a >> 13);
  endfunction
  function automatic int find_way(input logic [31:0] a);
    int s = set_of(a);
    if (mv[0][s] && mt[0][s] == tag_of(a)) return 0;
    if (mext && mv[1][s] && mt[1][s] == tag_of(a)) return 1;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, ncyc);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic model_step();
    int  s, w;
    bit  nv;
    case (mph)
      0: begin
        if (mpend) begin mph = 3; msw = 0; mpend = 0; end
        else if (fetch_valid) begin
          w = find_way(fa);
          s = set_of(fa);
          if (w >= 0) begin
            if (mext) ml[s] = (w == 0);
          end else begin
            mph = 1;
            mline = {fa[31:5], 5'b0};
            if (!mext || !mv[0][s]) mway = 0;
            else if (!mv[1][s]) mway = 1;
            else mway = ml[s] ? 1 : 0;
          end
        end
      end
      1: if (mem_req_ready) begin mph = 2; mbeat = 0; end
      2: if (mem_beat_valid) begin
        s = set_of(mline);
        md[mway][s][mbeat] = mem_beat_data;
        if (mbeat == 7) begin
          if (mway == 0 || mext) begin mv[mway][s] = 1; mt[mway][s] = tag_of(mline); end
          if (mext) ml[s] = (mway == 0);
          mph = 0;
        end
        mbeat++;
      end
      3: begin
        mv[0][msw] = 0; mv[1][msw] = 0;
        if (msw == 255) mph = 0;
        msw++;
      end
      default: mph = 0;
    endcase
    if (inv_all) mpend = 1;
    if (cfg_we) begin
      nv = cfg_ext;
      if (nv != mext) for (int i = 0; i < 256; i++) mv[1][i] = 0;
      mext = nv;
    end
  endtask

  // One clock: drive memory side, compare outputs, advance the model.
  task automatic cyc();
    bit exp_ready;
    int w;
    rnd = rnd * 32'd1103515245 + 32'd12345;
    mem_req_ready  = rnd[16] | rnd[21];
    mem_beat_valid = rnd[18] | rnd[19];
    mem_beat_data  = (mph == 2) ? memfun(mline + 32'(mbeat * 4)) : rnd;
    #2;
    w = find_way(fa);
    exp_ready = (mph == 0) && !mpend && fetch_valid && (w >= 0);
    last_ready = fetch_ready;
    check(fetch_ready == exp_ready, cur_req, "fetch_ready", 32'(fetch_ready), 32'(exp_ready));
    if (fetch_ready && exp_ready)
      check(fetch_data == md[w][set_of(fa)][fa[4:2]], cur_req, "fetch_data",
            fetch_data, md[w][set_of(fa)][fa[4:2]]);
    check(mem_req_valid == (mph == 1), "R10", "mem_req_valid",
          32'(mem_req_valid), 32'(mph == 1));
    if (mph == 1)
      check(mem_req_addr == mline, "R2", "mem_req_addr", mem_req_addr, mline);
    @(posedge clk);
    model_step();
    @(negedge clk);
    ncyc++;
    if (ncyc > 150000) begin
      check(0, cur_req, "watchdog", 32'(ncyc), 32'd150000);
      finish_run();
    end
  endtask

  task automatic fetch(input logic [31:0] a, output int lat);
    fetch_valid = 1'b1; fa = a; lat = 0;
    do begin
      cyc();
      lat++;
    end while (!last_ready && lat < 3000);
    fetch_valid = 1'b0;
    if (lat >= 3000) check(0, cur_req, "fetch hung", 32'(lat), 32'd0);
  endtask

  task automatic expect_fetch(input logic [31:0] a, input bit hit, input string req);
    int lat;
    cur_req = req;
    fetch(a, lat);
    if (hit) check(lat == 1, req, "hit latency", 32'(lat), 32'd1);
    else     check(lat >= 11, req, "miss latency", 32'(lat), 32'd11);
  endtask

  task automatic set_mode(input bit v);
    cfg_we = 1'b1; cfg_ext = v; cyc(); cfg_we = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0000_1040;
  localparam logic [31:0] B = A + 32'h2000;
  localparam logic [31:0] C = A + 32'h4000;
  localparam logic [31:0] D = A + 32'h6000;
  localparam logic [31:0] E = 32'h0003_2080;

  initial begin
    int lat;
    logic [31:0] pool [5];
    pool = '{A, B, C, D, E};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fetch_ready == 1'b0, "R1", "ready in reset", 32'(fetch_ready), 32'd0);
    check(mem_req_valid == 1'b0, "R1", "req in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    expect_fetch(A, 0, "R1");
    // R9 / R2: words of one line hit, the next line misses
    expect_fetch(A + 4, 1, "R9");
    expect_fetch(A + 28, 1, "R2");
    expect_fetch(A + 32, 0, "R2");
    expect_fetch(A, 1, "R9");
    // R3: direct-mapped conflict
    expect_fetch(B, 0, "R3");
    expect_fetch(A, 0, "R3");
    expect_fetch(A + 8, 1, "R3");
    // R6 / R4: switch to 2-way, way 0 kept
    set_mode(1);
    expect_fetch(A, 1, "R6");
    expect_fetch(B, 0, "R4");
    expect_fetch(A, 1, "R4");
    expect_fetch(B, 1, "R4");
    // R5: LRU victim choice
    expect_fetch(C, 0, "R5");
    expect_fetch(B, 1, "R5");
    expect_fetch(A, 0, "R5");
    expect_fetch(B, 1, "R5");
    expect_fetch(C, 0, "R5");
    expect_fetch(B, 1, "R5");
    // R6: back to direct-mapped drops way 1
    set_mode(0);
    expect_fetch(C, 1, "R6");
    expect_fetch(B, 0, "R6");
    set_mode(1);
    expect_fetch(B, 1, "R6");
    expect_fetch(C, 0, "R6");
    // R8: invalidate, new memory contents must be seen
    inv_all = 1'b1; cyc(); inv_all = 1'b0;
    epoch = 32'h5A5A_0F0F;
    cur_req = "R8";
    fetch(B, lat);
    check(lat >= 256, "R8", "sweep latency", 32'(lat), 32'd256);
    expect_fetch(C, 0, "R8");
    expect_fetch(B + 12, 1, "R8");
    // R7: miss delivery after the full line
    expect_fetch(E, 0, "R7");
    expect_fetch(E + 20, 1, "R7");
    // Random mix against the model
    cur_req = "R5";
    for (int n = 0; n < 1500; n++) begin
      fetch_valid = 1'b1;
      fa = pool[rnd[10:8] % 5] + {27'd0, rnd[4:2], 2'b00};
      do begin
        cfg_we  = (rnd[27:22] == 6'd5);
        cfg_ext = rnd[3];
        inv_all = (rnd[29:22] == 8'd9);
        cyc();
        cfg_we = 1'b0; inv_all = 1'b0;
      end while (!last_ready);
      fetch_valid = 1'b0;
      if (rnd[12]) cyc();
    end
    finish_run();
  end

endmodule